// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits on the system-clock side of a 16-bit asynchronous static RAM array that is built from two independent 8-bit halves. It accepts one word request at a time through a valid/ready handshake and turns it into a correctly timed bus cycle. The external pins it drives are a shared 19-bit address, one select and one write strobe per byte half, a single shared output enable, and a data bus. The data bus is split into an output word, an input word and a drive enable, so that the pad ring can form the tristate.

Writes carry a 2-bit byte-enable mask, and only the enabled halves are selected and strobed. Reads always open both halves and return the full word together with a one-cycle done pulse. Every phase length is computed at elaboration from nanosecond timing parameters and the clock period, each rounded up to whole clocks. After every read the controller inserts a turnaround gap, so that the memory has released the bus before the controller can drive it again.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Out of reset and whenever idle, both selects, both write strobes and the output enable are high (inactive), the data drive enable and done are low, and ready is high.
- R2: Lane 0 is data bits 7:0 with `mem_cs_n[0]`, `mem_we_n[0]` and `req_be[0]`. Lane 1 is bits 15:8 with index 1 of each. A word written under a partial mask reads back with only the enabled bytes changed.
- R3: A write with a mask bit set lasts PULSE+3 clocks after acceptance, each phase named for what the enabled lanes' select and strobe show. A setup clock with the select low and the strobe high. PULSE clocks with the strobe low. A hold clock with the strobe high and the select still low. An idle clock carrying done. PULSE is the largest of ceil(25 ns/clk), ceil(35 ns/clk)-2, ceil(20 ns/clk)-1 and 1, which is 2 at a 20 ns clock.
- R4: During a write the output enable stays high. The drive enable is high from the setup clock through the hold clock, so it falls only after the strobe has returned high. `mem_dq_out` holds the request data throughout.
- R5: A lane whose mask bit is 0 is never selected or strobed. With mask 00 the write keeps the same length and still gives done, while no select or strobe goes low.
- R6: A read holds both selects and the output enable low for ACC clocks. ACC is the largest of ceil(35 ns/clk), ceil(25 ns/clk) and 1, which is 2 at 20 ns. The data on `mem_dq_in` is captured at the last of those edges and appears on `rsp_rdata` in the next clock, together with the done pulse.
- R7: Each read is followed by TURN clocks with every select and the output enable high and ready low. TURN is max(1, ceil(15 ns/clk)), which is 1 at 20 ns. The done pulse falls in the first of these clocks.
- R8: Ready is high only while idle. A request is taken on an edge where valid and ready are both high, and done lasts exactly one clock.
- R9: The output enable is never low while either write strobe is low or while the drive enable is high.
- R10: The address stays stable while any select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane write mask |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with done after a read |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 2 | Per-lane select, active low |
| mem_we_n | output | 2 | Per-lane write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench targets partial-mask writes followed by full-word readback. A lane swap or a mask that is ignored would corrupt the byte that should have survived. It exercises a mask of 00: a controller that strobes anyway would overwrite stored data, and one that skips the cycle would never give done. Reads followed at once by writes expose a missing turnaround, because the drive enable would rise while the memory may still be driving. A drive enable that drops together with the strobe, or a capture taken one clock early, shows up against the per-clock expected pin pattern and the returned word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WSET   = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WHOLD  = 3'd3,
      ST_RACC   = 3'd4,
      ST_RTURN  = 3'd5
   } ctl_state_t;

   // whole clocks needed to cover a time in ns
   function automatic int cyc_ceil(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down counter that times one phase; last is high in the final clock.
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_drive.sv
// Registered per-lane select and write strobe, one flop pair per lane.
module sram_lane_drive #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] sel_d,
   input  logic [LANES-1:0] stb_d,
   output logic [LANES-1:0] cs_n,
   output logic [LANES-1:0] we_n
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_n[l] <= 1'b1;
            we_n[l] <= 1'b1;
         end else begin
            cs_n[l] <= ~sel_d[l];
            we_n[l] <= ~(stb_d[l] & sel_d[l]);
         end
      end
   end
endmodule

// File: rtl/sram_read_capture.sv
// Samples the returned word on the last access edge of a read.
module sram_read_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] data_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_out <= '0;
      else if (capture)
         data_out <= bus_in;
   end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 16,
   parameter int CLK_NS   = 20,
   parameter int T_WC_NS  = 35,
   parameter int T_WP_NS  = 25,
   parameter int T_DW_NS  = 20,
   parameter int T_RC_NS  = 35,
   parameter int T_AA_NS  = 35,
   parameter int T_OE_NS  = 25,
   parameter int T_HZ_NS  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_cs_n,
   output logic [1:0]        mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int LANES     = DATA_W / 8;
   localparam int PULSE_CYC = imax(imax(imax(cyc_ceil(T_WP_NS, CLK_NS),
                                             cyc_ceil(T_WC_NS, CLK_NS) - 2),
                                        cyc_ceil(T_DW_NS, CLK_NS) - 1), 1);
   localparam int ACC_CYC   = imax(imax(imax(cyc_ceil(T_RC_NS, CLK_NS),
                                             cyc_ceil(T_AA_NS, CLK_NS)),
                                        cyc_ceil(T_OE_NS, CLK_NS)), 1);
   localparam int TURN_CYC  = imax(1, cyc_ceil(T_HZ_NS, CLK_NS));
   localparam int LONGEST   = imax(imax(PULSE_CYC, ACC_CYC), TURN_CYC);
   localparam int CNT_W     = imax(1, $clog2(LONGEST + 1));
   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

   // elaboration checks
   if (CLK_NS <= 0) begin : g_bad_clk
      $error("CLK_NS must be positive");
   end
   if (DATA_W != 16) begin : g_bad_width
      $error("DATA_W must be 16: two 8-bit lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   ctl_state_t             state_q, state_d;
   logic                   t_load, t_last, capture, done_d, accept;
   logic [CNT_W-1:0]       t_val;
   logic [LANES-1:0]       be_q, be_d, sel_d, stb_d;
   logic                   wr_phase_d;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic                   oe_n_q, dq_oe_q, done_q;

   // next-state decode
   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      capture = 1'b0;
      done_d  = 1'b0;
      accept  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               t_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WSET;
                  t_val   = '0;
               end else begin
                  state_d = ST_RACC;
                  t_val   = ACC_LD;
               end
            end
         end
         ST_WSET: begin
            if (t_last) begin
               state_d = ST_WPULSE;
               t_load  = 1'b1;
               t_val   = PULSE_LD;
            end
         end
         ST_WPULSE: begin
            if (t_last) begin
               state_d = ST_WHOLD;
               t_load  = 1'b1;
               t_val   = '0;
            end
         end
         ST_WHOLD: begin
            if (t_last) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         ST_RACC: begin
            if (t_last) begin
               state_d = ST_RTURN;
               t_load  = 1'b1;
               t_val   = TURN_LD;
               capture = 1'b1;
               done_d  = 1'b1;
            end
         end
         ST_RTURN: begin
            if (t_last)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign be_d       = accept ? req_be : be_q;
   assign wr_phase_d = (state_d == ST_WSET) || (state_d == ST_WPULSE) ||
                       (state_d == ST_WHOLD);
   assign sel_d      = {LANES{state_d == ST_RACC}} | ({LANES{wr_phase_d}} & be_d);
   assign stb_d      = {LANES{state_d == ST_WPULSE}} & be_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         oe_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         be_q    <= be_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         oe_n_q  <= (state_d != ST_RACC);
         dq_oe_q <= wr_phase_d;
         done_q  <= done_d;
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   sram_lane_drive #(.LANES(LANES)) u_lanes (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_d (sel_d),
      .stb_d (stb_d),
      .cs_n  (mem_cs_n),
      .we_n  (mem_we_n)
   );

   sram_read_capture #(.DATA_W(DATA_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .bus_in   (mem_dq_in),
      .data_out (rsp_rdata)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_done   = done_q;
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_cs_n,
   input logic [1:0]        mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);
   // R5
   strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_we_n) & mem_cs_n) == 2'b00);

   // R9
   oe_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (&mem_we_n));

   // R9
   bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R4
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> $past(&mem_we_n));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(~mem_cs_n)) && $past(|(~mem_cs_n))) |-> $stable(mem_addr));

   // R7
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (!req_ready && !mem_dq_oe));

   // R1
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ((&mem_cs_n) && !mem_dq_oe && mem_oe_n));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_done, mem_oe_n, mem_dq_oe;
   logic [15:0] rsp_rdata, mem_dq_out;
   logic [15:0] mem_dq_in = '0;
   logic [18:0] mem_addr;
   logic [1:0]  mem_cs_n, mem_we_n;

   sram_cycle_ctrl uut (.*);

   typedef struct packed {
      logic [1:0] cs_n; logic [1:0] we_n;
      logic oe_n; logic dq_oe; logic done; logic ready;
   } vec_t;
   localparam vec_t IDLE_V = 8'b11_11_1_0_0_1;

   int checks = 0, errors = 0;
   bit running = 1'b0;
   vec_t  exp_q[$];
   string tag_q[$];
   logic [18:0] cur_addr = '0;
   logic [15:0] cur_data = '0, cur_rd = '0;
   bit    cur_is_rd = 1'b0;
   string cur_tag = "R6";
   logic [7:0] bank_lo[int], bank_hi[int];
   logic [7:0] ref_lo[int],  ref_hi[int];

   task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
      end
   endtask

   // behavioural memory: stores while select and strobe are low, drives on read
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_cs_n[0] === 1'b0 && mem_we_n[0] === 1'b0) bank_lo[int'(mem_addr)] = mem_dq_out[7:0];
         if (mem_cs_n[1] === 1'b0 && mem_we_n[1] === 1'b0) bank_hi[int'(mem_addr)] = mem_dq_out[15:8];
      end
      if (mem_oe_n === 1'b0 && mem_cs_n === 2'b00)
         mem_dq_in <= {bank_hi.exists(int'(mem_addr)) ? bank_hi[int'(mem_addr)] : 8'hA5,
                       bank_lo.exists(int'(mem_addr)) ? bank_lo[int'(mem_addr)] : 8'hA5};
      else
         mem_dq_in <= 16'h0000;
   end

   // per-clock comparison against the expected pin timeline
   always @(negedge clk) begin : cmp
      vec_t e, a;
      string t;
      if (rst_n && running) begin
         if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
         end else begin
            e = IDLE_V;
            t = "R1";
         end
         a = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready};
         chk(a === e, t, 32'(a), 32'(e));
         if (e.cs_n != 2'b11) chk(mem_addr === cur_addr, "R10", 32'(mem_addr), 32'(cur_addr));
         if (e.dq_oe) chk(mem_dq_out === cur_data, "R4", 32'(mem_dq_out), 32'(cur_data));
         if (e.done && cur_is_rd) chk(rsp_rdata === cur_rd, cur_tag, 32'(rsp_rdata), 32'(cur_rd));
         chk(mem_oe_n || ((&mem_we_n) && !mem_dq_oe), "R9", 32'({mem_oe_n, mem_we_n, mem_dq_oe}), 32'h0);
      end
   end

   // PULSE=2, ACC=2, TURN=1 at a 20 ns clock (R3, R6, R7)
   task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be, input string rtag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      cur_addr = a; cur_is_rd = !wr; cur_tag = rtag;
      if (wr) begin
         cur_data = d;
         exp_q.push_back({~be, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0}); tag_q.push_back("R3");
         repeat (2) begin
            exp_q.push_back({~be, ~be, 1'b1, 1'b1, 1'b0, 1'b0});
            tag_q.push_back(be == 2'b11 ? "R3" : "R5");
         end
         exp_q.push_back({~be, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0}); tag_q.push_back("R4");
         exp_q.push_back(8'b11_11_1_0_1_1);                     tag_q.push_back("R8");
         if (be[0]) ref_lo[int'(a)] = d[7:0];
         if (be[1]) ref_hi[int'(a)] = d[15:8];
      end else begin
         cur_rd = {ref_hi.exists(int'(a)) ? ref_hi[int'(a)] : 8'hA5,
                   ref_lo.exists(int'(a)) ? ref_lo[int'(a)] : 8'hA5};
         repeat (2) begin
            exp_q.push_back(8'b00_11_0_0_0_0); tag_q.push_back("R6");
         end
         exp_q.push_back(8'b11_11_1_0_1_0); tag_q.push_back("R7");
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog act=hung exp=complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready} === IDLE_V, "R1",
          32'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready}), 32'(IDLE_V));
      rst_n = 1'b1;
      running = 1'b1;
      repeat (2) @(negedge clk);
      issue(1'b1, 19'h12345, 16'hBEEF, 2'b11, "R3");
      issue(1'b0, 19'h12345, 16'h0,    2'b11, "R6");
      issue(1'b1, 19'h12345, 16'h1122, 2'b01, "R2");  // lower lane only
      issue(1'b0, 19'h12345, 16'h0,    2'b11, "R2");
      issue(1'b1, 19'h12345, 16'h7733, 2'b10, "R2");  // upper lane only
      issue(1'b0, 19'h12345, 16'h0,    2'b11, "R2");
      issue(1'b1, 19'h12345, 16'h0000, 2'b00, "R5");  // no lane
      issue(1'b0, 19'h12345, 16'h0,    2'b11, "R5");
      issue(1'b1, 19'h7FFFF, 16'hA55A, 2'b11, "R3");
      issue(1'b1, 19'h00000, 16'h5AA5, 2'b11, "R3");
      issue(1'b0, 19'h7FFFF, 16'h0,    2'b11, "R6");
      issue(1'b1, 19'h7FFFF, 16'h0F0F, 2'b11, "R7");  // write right after read
      issue(1'b0, 19'h00000, 16'h0,    2'b11, "R6");
      issue(1'b0, 19'h7FFFF, 16'h0,    2'b11, "R7");  // read after read
      for (int i = 0; i < 8; i++)
         issue(1'b1, 19'(i * 19'h09249), 16'(16'h1357 * (i + 1)), 2'(i % 4), "R5");
      for (int i = 0; i < 8; i++)
         issue(1'b0, 19'(i * 19'h09249), 16'h0, 2'b11, "R2");
      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule